// File: doc/BRIEF.md
# Oversampled Serial Receiver with Held-Frame Interrupt

This block recovers asynchronous serial frames from a single input line. The line is sampled on a 16x oversampling tick. A frame has one start bit, followed by 7, 8 or 9 data bits sent least significant bit first. In the 7-bit and 8-bit modes an optional parity bit follows the data. The frame ends with a stop bit.

The receiver always checks exactly one stop bit. If the sender adds further stop bits, they are seen as idle line. Each completed frame goes into a one-entry holding register, together with its own parity-error and framing-error status. A level interrupt is raised while that register is full and the receive interrupt is enabled. Reading the register through a one-cycle read strobe empties it.

Baud-rate generation is outside the block. The caller supplies the tick, which must last one clock cycle per oversampling period.

Top module: `ser_rx_top`

## Requirements
- R1: After reset, full_o, perr_o, ferr_o, ovr_o and irq_o are 0 and data_o is 0.
- R2: A low level on the line starts a frame only if the line is still low at the mid-start sample, 8 ticks after the falling edge. A shorter low pulse stores nothing, and the receiver then accepts the next valid frame.
- R3: Data bits arrive least significant bit first. The length code len_sel_i selects the frame size: 0 = 7 bits in data_o[6:0] with data_o[8:7] = 0; 1 or 3 = 8 bits in data_o[7:0] with data_o[8] = 0; 2 = 9 bits.
- R4: With len_sel_i = 2, no parity bit is expected even when par_en_i = 1. The ninth received bit appears in data_o[8], and perr_o stays 0.
- R5: With par_en_i = 1 in the 7-bit or 8-bit mode, the bit after the data is checked according to par_sel_i: 0 odd, 1 even, 2 always 1, 3 always 0. A mismatch sets perr_o for the stored frame.
- R6: Exactly one stop bit is sampled. If it reads low, ferr_o is set and the frame is still stored. A new start bit may follow directly after a single stop bit.
- R7: Storing a frame sets full_o. A one-cycle rd_i while no frame completes clears full_o.
- R8: irq_o is 1 exactly while full_o and rx_ie_i are both 1. Clearing rx_ie_i or reading the buffer removes it.
- R9: A frame completing while full_o = 1 and rd_i = 0 sets ovr_o and replaces the held data. A read clears ovr_o.
- R10: A read in the same cycle as a frame completion stores the new frame. full_o stays 1 and ovr_o is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rxd_i | input | 1 | Serial line, idle high |
| tick16_i | input | 1 | One-cycle pulse per oversampling period |
| len_sel_i | input | 2 | Data length code |
| par_en_i | input | 1 | Parity check enable |
| par_sel_i | input | 2 | Parity type code |
| rd_i | input | 1 | Read strobe for the holding register |
| rx_ie_i | input | 1 | Receive interrupt enable |
| data_o | output | 9 | Held frame data |
| full_o | output | 1 | Holding register occupied |
| perr_o | output | 1 | Parity error of held frame |
| ferr_o | output | 1 | Framing error of held frame |
| ovr_o | output | 1 | Overrun since last read |
| irq_o | output | 1 | Receive interrupt level |

## Verification
Frame completion and a software read can fall in the same clock cycle. The outcome depends on which of them the holding register gives priority to. The bench counts clock cycles from the start bit so that rd_i lands exactly on the completion edge. Both cases are judged: the buffer must hold the new data with full_o set and no overrun, and that result is compared with a completion while the buffer is full and unread, which must raise ovr_o.

// File: rtl/ser_rx_pkg.sv
package ser_rx_pkg;
  localparam int DATA_W = 9;

  typedef enum logic [1:0] {
    LEN7  = 2'd0,
    LEN8  = 2'd1,
    LEN9  = 2'd2,
    LEN8B = 2'd3
  } len_e;

  typedef enum logic [1:0] {
    PAR_ODD   = 2'd0,
    PAR_EVEN  = 2'd1,
    PAR_ONE   = 2'd2,
    PAR_ZERO  = 2'd3
  } par_e;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic              perr;
    logic              ferr;
  } frame_t;
endpackage

// File: rtl/ser_rx_sync.sv
module ser_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '1;
    else         q <= {q[STAGES-2:0], d_i};
  end

  assign q_o = q[STAGES-1];
endmodule

// File: rtl/ser_rx_fsm.sv
module ser_rx_fsm
  import ser_rx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_i,
  input  logic              tick_i,
  input  logic [1:0]        len_i,
  input  logic              has_par_i,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o,
  output logic              par_bit_o,
  output logic              ferr_o
);
  localparam int CNT_W = $clog2(OSR);
  localparam int IDX_W = $clog2(DATA_W + 2);
  localparam logic [CNT_W-1:0] MID  = CNT_W'(OSR / 2 - 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(OSR - 1);

  typedef enum logic [1:0] {S_IDLE, S_START, S_BITS, S_STOP} st_e;

  st_e              st;
  logic [CNT_W-1:0] cnt;
  logic [IDX_W-1:0] idx;
  logic [IDX_W-1:0] n_data;
  logic [IDX_W-1:0] last_idx;
  logic             sample;

  always_comb begin
    unique case (len_e'(len_i))
      LEN7:    n_data = IDX_W'(7);
      LEN9:    n_data = IDX_W'(9);
      default: n_data = IDX_W'(8);
    endcase
    last_idx = n_data - IDX_W'(1) + IDX_W'(has_par_i);
  end

  assign sample = tick_i && (cnt == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st        <= S_IDLE;
      cnt       <= '0;
      idx       <= '0;
      data_o    <= '0;
      par_bit_o <= 1'b0;
      ferr_o    <= 1'b0;
      done_o    <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (st)
        S_IDLE: if (tick_i && !rx_i) begin
          st  <= S_START;
          cnt <= '0;
        end
        S_START: if (tick_i) begin
          if (cnt == MID) begin
            // reject glitches still high at mid-start
            if (!rx_i) begin
              st     <= S_BITS;
              cnt    <= '0;
              idx    <= '0;
              data_o <= '0;
            end else begin
              st <= S_IDLE;
            end
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        S_BITS: if (tick_i) begin
          if (sample) begin
            cnt <= '0;
            if (idx < n_data) data_o <= data_o | (DATA_W'(rx_i) << idx);
            else              par_bit_o <= rx_i;
            if (idx == last_idx) st <= S_STOP;
            else                 idx <= idx + IDX_W'(1);
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        S_STOP: if (tick_i) begin
          if (sample) begin
            cnt    <= '0;
            done_o <= 1'b1;
            ferr_o <= !rx_i;
            st     <= S_IDLE;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ser_rx_par.sv
module ser_rx_par
  import ser_rx_pkg::*;
(
  input  logic [DATA_W-1:0] data_i,
  input  logic              par_bit_i,
  input  logic [1:0]        sel_i,
  input  logic              en_i,
  output logic              err_o
);
  logic sum;

  assign sum = ^data_i ^ par_bit_i;

  always_comb begin
    unique case (par_e'(sel_i))
      PAR_ODD:  err_o = !sum;
      PAR_EVEN: err_o = sum;
      PAR_ONE:  err_o = !par_bit_i;
      default:  err_o = par_bit_i;
    endcase
    if (!en_i) err_o = 1'b0;
  end
endmodule

// File: rtl/ser_rx_buf.sv
module ser_rx_buf
  import ser_rx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              store_i,
  input  frame_t            frame_i,
  input  logic              rd_i,
  input  logic              ie_i,
  output logic [DATA_W-1:0] data_o,
  output logic              full_o,
  output logic              perr_o,
  output logic              ferr_o,
  output logic              ovr_o,
  output logic              irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o <= '0;
      full_o <= 1'b0;
      perr_o <= 1'b0;
      ferr_o <= 1'b0;
      ovr_o  <= 1'b0;
    end else begin
      if (store_i) begin
        data_o <= frame_i.data;
        perr_o <= frame_i.perr;
        ferr_o <= frame_i.ferr;
        full_o <= 1'b1;
      end else if (rd_i) begin
        full_o <= 1'b0;
      end
      // completion wins over a same-cycle read
      if (store_i && full_o && !rd_i) ovr_o <= 1'b1;
      else if (rd_i)                  ovr_o <= 1'b0;
    end
  end

  assign irq_o = full_o & ie_i;
endmodule

// File: rtl/ser_rx_top.sv
module ser_rx_top
  import ser_rx_pkg::*;
#(
  parameter int OSR         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rxd_i,
  input  logic              tick16_i,
  input  logic [1:0]        len_sel_i,
  input  logic              par_en_i,
  input  logic [1:0]        par_sel_i,
  input  logic              rd_i,
  input  logic              rx_ie_i,
  output logic [DATA_W-1:0] data_o,
  output logic              full_o,
  output logic              perr_o,
  output logic              ferr_o,
  output logic              ovr_o,
  output logic              irq_o
);
  logic              rx_s;
  logic              has_par;
  logic              frame_done;
  logic [DATA_W-1:0] shift_data;
  logic              par_bit;
  logic              stop_err;
  logic              par_err;
  frame_t            frame;

  assign has_par = par_en_i && (len_e'(len_sel_i) != LEN9);

  ser_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (rxd_i),
    .q_o   (rx_s)
  );

  ser_rx_fsm #(.OSR(OSR)) u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rx_i     (rx_s),
    .tick_i   (tick16_i),
    .len_i    (len_sel_i),
    .has_par_i(has_par),
    .done_o   (frame_done),
    .data_o   (shift_data),
    .par_bit_o(par_bit),
    .ferr_o   (stop_err)
  );

  ser_rx_par u_par (
    .data_i   (shift_data),
    .par_bit_i(par_bit),
    .sel_i    (par_sel_i),
    .en_i     (has_par),
    .err_o    (par_err)
  );

  assign frame = '{data: shift_data, perr: par_err, ferr: stop_err};

  ser_rx_buf u_buf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .store_i(frame_done),
    .frame_i(frame),
    .rd_i   (rd_i),
    .ie_i   (rx_ie_i),
    .data_o (data_o),
    .full_o (full_o),
    .perr_o (perr_o),
    .ferr_o (ferr_o),
    .ovr_o  (ovr_o),
    .irq_o  (irq_o)
  );
endmodule

// File: rtl/ser_rx_chk.sv
module ser_rx_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       rd_i,
  input logic       rx_ie_i,
  input logic [1:0] len_sel_i,
  input logic [1:0] data_hi_i,
  input logic       full_o,
  input logic       ovr_o,
  input logic       irq_o,
  input logic       store_i
);
  // R3
  short_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    store_i && len_sel_i == 2'd0 |=> data_hi_i == 2'b00);

  // R7
  store_sets_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    store_i |=> full_o);

  // R7
  full_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && !store_i |=> !full_o);

  // R8
  irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> full_o && rx_ie_i);

  // R8
  irq_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rx_ie_i) |-> !irq_o);

  // R9
  overrun_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    store_i && full_o && !rd_i |=> ovr_o);

  // R10
  same_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    store_i && rd_i |=> full_o && !ovr_o);
endmodule

bind ser_rx_top ser_rx_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .rd_i     (rd_i),
  .rx_ie_i  (rx_ie_i),
  .len_sel_i(len_sel_i),
  .data_hi_i(data_o[8:7]),
  .full_o   (full_o),
  .ovr_o    (ovr_o),
  .irq_o    (irq_o),
  .store_i  (frame_done)
);

// File: tb/sim_ser_rx_top.sv
`timescale 1ns/1ps
module sim_ser_rx_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       rxd_i = 1'b1;
  logic       tick16_i = 1'b1;
  logic [1:0] len_sel_i = 2'd1;
  logic       par_en_i = 1'b0;
  logic [1:0] par_sel_i = 2'd0;
  logic       rd_i = 1'b0;
  logic       rx_ie_i = 1'b0;
  logic [8:0] data_o;
  logic       full_o, perr_o, ferr_o, ovr_o, irq_o;

  int checks = 0;
  int failures = 0;

  always #10 clk_i = ~clk_i;

  ser_rx_top u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .rxd_i(rxd_i), .tick16_i(tick16_i),
    .len_sel_i(len_sel_i), .par_en_i(par_en_i), .par_sel_i(par_sel_i),
    .rd_i(rd_i), .rx_ie_i(rx_ie_i), .data_o(data_o), .full_o(full_o),
    .perr_o(perr_o), .ferr_o(ferr_o), .ovr_o(ovr_o), .irq_o(irq_o)
  );

  // {len[1:0], par_en, par_sel[1:0], data[8:0], flip_parity, stop_value}
  localparam logic [15:0] VECS [8] = '{
    {2'd1, 1'b0, 2'd0, 9'h0A5, 1'b0, 1'b1},
    {2'd0, 1'b0, 2'd0, 9'h1FF, 1'b0, 1'b1},
    {2'd1, 1'b1, 2'd0, 9'h03C, 1'b0, 1'b1},
    {2'd3, 1'b1, 2'd1, 9'h03D, 1'b1, 1'b1},
    {2'd0, 1'b1, 2'd2, 9'h055, 1'b0, 1'b1},
    {2'd0, 1'b1, 2'd3, 9'h02A, 1'b1, 1'b1},
    {2'd2, 1'b1, 2'd0, 9'h1C3, 1'b0, 1'b1},
    {2'd1, 1'b0, 2'd0, 9'h081, 1'b0, 1'b0}
  };

  task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [8:0] mask_data(input logic [1:0] len, input logic [8:0] d);
    if (len == 2'd0)      return d & 9'h07F;
    else if (len == 2'd2) return d;
    else                  return d & 9'h0FF;
  endfunction

  task automatic send_frame(input logic [1:0] len, input logic pen, input logic [1:0] psel,
                            input logic [8:0] d, input logic flip, input logic stopv,
                            input int rd_at, input int gap);
    logic [15:0] bits;
    int nb;
    int nd;
    logic p;
    logic [8:0] dm;
    len_sel_i = len;
    par_en_i  = pen;
    par_sel_i = psel;
    nd = (len == 2'd0) ? 7 : (len == 2'd2) ? 9 : 8;
    dm = mask_data(len, d);
    bits = '0;
    bits[0] = 1'b0;
    nb = 1;
    for (int k = 0; k < nd; k++) begin
      bits[nb] = d[k];
      nb++;
    end
    if (pen && len != 2'd2) begin
      case (psel)
        2'd0:    p = ~(^dm);
        2'd1:    p = ^dm;
        2'd2:    p = 1'b1;
        default: p = 1'b0;
      endcase
      bits[nb] = p ^ flip;
      nb++;
    end
    bits[nb] = stopv;
    nb++;
    for (int j = 0; j < nb * 16; j++) begin
      @(negedge clk_i);
      rxd_i = bits[j / 16];
      rd_i  = (j == rd_at);
    end
    @(negedge clk_i);
    rxd_i = 1'b1;
    rd_i  = 1'b0;
    for (int g = 0; g < gap; g++) @(negedge clk_i);
  endtask

  task automatic do_read();
    @(negedge clk_i);
    rd_i = 1'b1;
    @(negedge clk_i);
    rd_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    check("R1 data", data_o, 9'h000);
    check("R1 flags", {4'b0, full_o, perr_o, ferr_o, ovr_o, irq_o}, 9'h000);
    rst_ni = 1'b1;
    repeat (5) @(negedge clk_i);

    foreach (VECS[i]) begin
      logic [1:0] len;
      logic pen, flip, stopv;
      logic [1:0] psel;
      logic [8:0] d;
      {len, pen, psel, d, flip, stopv} = VECS[i];
      rx_ie_i = i[0];
      send_frame(len, pen, psel, d, flip, stopv, -1, 20);
      check("R3 R4 data", data_o, mask_data(len, d));
      check("R5 R4 parity error", {8'b0, perr_o}, {8'b0, pen && len != 2'd2 && flip});
      check("R6 framing error", {8'b0, ferr_o}, {8'b0, !stopv});
      check("R7 full set", {8'b0, full_o}, 9'h001);
      check("R8 irq level", {8'b0, irq_o}, {8'b0, rx_ie_i});
      do_read();
      @(negedge clk_i);
      check("R7 full cleared by read", {8'b0, full_o}, 9'h000);
      check("R8 irq removed by read", {8'b0, irq_o}, 9'h000);
    end

    // R2 short low pulse must not start a frame
    @(negedge clk_i);
    rxd_i = 1'b0;
    repeat (5) @(negedge clk_i);
    rxd_i = 1'b1;
    repeat (40) @(negedge clk_i);
    check("R2 glitch ignored", {8'b0, full_o}, 9'h000);
    send_frame(2'd1, 1'b0, 2'd0, 9'h05A, 1'b0, 1'b1, -1, 20);
    check("R2 frame after glitch", data_o, 9'h05A);

    // R8 enable toggled while full
    rx_ie_i = 1'b0;
    @(negedge clk_i);
    check("R8 irq off with enable low", {8'b0, irq_o}, 9'h000);
    rx_ie_i = 1'b1;
    @(negedge clk_i);
    check("R8 irq on with enable high", {8'b0, irq_o}, 9'h001);
    do_read();

    // R9 overrun, with R6 single stop bit back to back
    send_frame(2'd1, 1'b0, 2'd0, 9'h011, 1'b0, 1'b1, -1, 0);
    send_frame(2'd1, 1'b0, 2'd0, 9'h0E2, 1'b0, 1'b1, -1, 20);
    check("R6 back-to-back after one stop", data_o, 9'h0E2);
    check("R9 overrun set", {8'b0, ovr_o}, 9'h001);
    do_read();
    @(negedge clk_i);
    check("R9 overrun cleared by read", {7'b0, ovr_o, full_o}, 9'h000);

    // R10 read on the completion edge: 8 data bits, stop sample edge + 1
    send_frame(2'd1, 1'b0, 2'd0, 9'h033, 1'b0, 1'b1, -1, 20);
    send_frame(2'd1, 1'b0, 2'd0, 9'h0C4, 1'b0, 1'b1, 16 * 9 + 11, 20);
    check("R10 new data", data_o, 9'h0C4);
    check("R10 full kept", {8'b0, full_o}, 9'h001);
    check("R10 no overrun", {8'b0, ovr_o}, 9'h000);
    do_read();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule